// File: doc/BRIEF.md
# Dual Block Error Threshold Counters

This block counts transmission block errors for a line that is checked once per superframe. An upstream checker sends a one-cycle near-end error pulse when the local CRC check fails and a one-cycle far-end error pulse when the far end reports a failed check. Both pulses feed two 8-bit up-counters.

Counter two counts only far-end errors. Counter one has a mode input. In one setting it counts the errors from both ends, and in the other it counts near-end errors only. Each counter has a threshold register that software can write. When an increment carries a counter from below its threshold to at or above it, the block raises a one-cycle event request. The request carries the counter's identity, given by which request bit is set, and the new count. A separate interrupt stack collects these requests.

The selected counter's value is always visible on the read-back bus. A read strobe clears that counter, so each read returns the errors seen since the previous read.

Top module: `blk_err_thresh`

## Requirements
- R1: When `rst` is high at a clock edge, both counters become 0x00, both thresholds become 0xFF, and `evt_req` becomes 0.
- R2: When `mix_mode` = 1, counter one grows by the number of error pulses high in that cycle: `ne_err` plus `fe_err`, so 2 when both are high.
- R3: When `mix_mode` = 0, counter one grows by `ne_err` only, and `fe_err` has no effect on it.
- R4: Counter two grows by `fe_err` in every mode, and `ne_err` never changes it.
- R5: Each counter saturates at 0xFF and never wraps to a lower value.
- R6: `rd_data` shows counter one when `rd_sel` = 0 and counter two when `rd_sel` = 1, in the same cycle. When `rd_en` is high at an edge, the selected counter is cleared and the other counter is unaffected.
- R7: If a read strobe and an error pulse reach the same counter in one cycle, `rd_data` shows the old value and the counter becomes the increment of that cycle.
- R8: When `wr_en` is high at an edge, `wr_data` is stored as the threshold of counter one (`wr_sel` = 0) or counter two (`wr_sel` = 1). The new threshold applies to increments from the next cycle on.
- R9: When an increment takes a counter from below its threshold to at or above it, the request bit rises for exactly one cycle. This is `evt_req[0]` for counter one or `evt_req[1]` for counter two. It rises in the same cycle in which the new count appears. At that time `evt_cnt[7:0]` (counter one) or `evt_cnt[15:8]` (counter two) holds the new count. The event also fires when the count steps past the threshold without hitting it exactly.
- R10: A counter that stays at or above its threshold raises no further event, including when it stays saturated. A later crossing after a read clear fires again.
- R11: A threshold of 0x00 never raises an event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ne_err | input | 1 | Near-end block error pulse, one per failed superframe |
| fe_err | input | 1 | Far-end block error pulse, one per failed superframe |
| mix_mode | input | 1 | 1: counter one counts both sources; 0: near-end only |
| rd_en | input | 1 | Read strobe, clears the selected counter |
| rd_sel | input | 1 | Counter select for read-back (0 one, 1 two) |
| wr_en | input | 1 | Threshold write strobe |
| wr_sel | input | 1 | Threshold select for writes (0 one, 1 two) |
| wr_data | input | 8 | Threshold value to store |
| rd_data | output | 8 | Current value of the selected counter |
| evt_req | output | 2 | One-cycle threshold event requests, bit 0 counter one |
| evt_cnt | output | 16 | Count at the event, [7:0] counter one, [15:8] counter two |

## Verification
The assertions assume that the error inputs are single-cycle pulses sampled at the clock edge. They also assume that read and write strobes last one cycle and that select lines are steady while a strobe is high. The stimulus respects this. Every input change is made at the falling edge, each pulse or strobe is released one cycle later, and select lines are moved only while no strobe is active. The hold assertion for counter one in near-end-only mode relies on `mix_mode` being set before the pulse it governs. The bench therefore changes the mode only together with the error inputs at a falling edge.

// File: rtl/errcnt_pkg.sv
package errcnt_pkg;

    localparam int CNT_W   = 8;
    localparam int NUM_CNT = 2;
    localparam int INC_W   = 2;

    localparam logic [CNT_W-1:0] THR_RST = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [INC_W-1:0] inc_t;

    typedef enum logic {
        CNT_ONE = 1'b0,
        CNT_TWO = 1'b1
    } cnt_id_e;

    typedef struct packed {
        logic req;
        cnt_t val;
    } evt_t;

    function automatic cnt_t sat_add(input cnt_t a, input inc_t b);
        logic [CNT_W:0] s;
        s = {1'b0, a} + {{(CNT_W + 1 - INC_W){1'b0}}, b};
        return s[CNT_W] ? CNT_MAX : s[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/errcnt_incsel.sv
module errcnt_incsel
    import errcnt_pkg::*;
(
    input  logic ne_err,
    input  logic fe_err,
    input  logic mix_mode,
    output inc_t inc_one,
    output inc_t inc_two
);

    always_comb begin
        inc_one = inc_t'(ne_err);
        if (mix_mode) begin
            inc_one = inc_t'(ne_err) + inc_t'(fe_err);
        end
        inc_two = inc_t'(fe_err);
    end

endmodule

// File: rtl/errcnt_unit.sv
module errcnt_unit
    import errcnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  inc_t inc,
    input  logic clr,
    input  logic thr_we,
    input  cnt_t thr_wdata,
    output cnt_t cnt,
    output evt_t evt
);

    cnt_t cnt_q;
    cnt_t thr_q;
    evt_t evt_q;
    cnt_t base;
    cnt_t nxt;
    logic fire;

    always_comb begin
        base = clr ? '0 : cnt_q;
        nxt  = sat_add(base, inc);
        fire = (inc != '0) && (base < thr_q) && (nxt >= thr_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            thr_q <= THR_RST;
            evt_q <= '0;
        end else begin
            cnt_q     <= nxt;
            evt_q.req <= fire;
            if (fire) begin
                evt_q.val <= nxt;
            end
            if (thr_we) begin
                thr_q <= thr_wdata;
            end
        end
    end

    assign cnt = cnt_q;
    assign evt = evt_q;

    AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (cnt_q == '0) && !evt_q.req); // R1
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !clr |=> cnt_q >= $past(cnt_q)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr && inc == '0) |=> $stable(cnt_q)); // R4
    AST_CLR_RESTART: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt_q == cnt_t'($past(inc))); // R7
    AST_EVT_VALUE: assert property (@(posedge clk) disable iff (rst)
        evt_q.req |-> evt_q.val == cnt_q); // R9
    AST_ZERO_THR_SILENT: assert property (@(posedge clk) disable iff (rst)
        (thr_q == '0 && !thr_we) |=> !evt_q.req); // R11

endmodule

// File: rtl/blk_err_thresh.sv
module blk_err_thresh
    import errcnt_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ne_err,
    input  logic                     fe_err,
    input  logic                     mix_mode,
    input  logic                     rd_en,
    input  logic                     rd_sel,
    input  logic                     wr_en,
    input  logic                     wr_sel,
    input  logic [CNT_W-1:0]         wr_data,
    output logic [CNT_W-1:0]         rd_data,
    output logic [NUM_CNT-1:0]       evt_req,
    output logic [NUM_CNT*CNT_W-1:0] evt_cnt
);

    inc_t inc   [NUM_CNT];
    cnt_t cnt   [NUM_CNT];
    evt_t evt   [NUM_CNT];

    errcnt_incsel u_incsel (
        .ne_err   (ne_err),
        .fe_err   (fe_err),
        .mix_mode (mix_mode),
        .inc_one  (inc[CNT_ONE]),
        .inc_two  (inc[CNT_TWO])
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic clr_i;
        logic we_i;
        assign clr_i = rd_en && (rd_sel == cnt_id_e'(i));
        assign we_i  = wr_en && (wr_sel == cnt_id_e'(i));

        errcnt_unit u_unit (
            .clk       (clk),
            .rst       (rst),
            .inc       (inc[i]),
            .clr       (clr_i),
            .thr_we    (we_i),
            .thr_wdata (wr_data),
            .cnt       (cnt[i]),
            .evt       (evt[i])
        );

        assign evt_req[i]                   = evt[i].req;
        assign evt_cnt[i*CNT_W +: CNT_W]    = evt[i].val;
    end

    assign rd_data = cnt[rd_sel];

    AST_MODE_NE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!mix_mode && !ne_err && !(rd_en && rd_sel == CNT_ONE)) |=> $stable(cnt[CNT_ONE])); // R3
    AST_TWO_IGNORES_NE: assert property (@(posedge clk) disable iff (rst)
        (!fe_err && !(rd_en && rd_sel == CNT_TWO)) |=> $stable(cnt[CNT_TWO])); // R4
    AST_MIX_DOUBLE: assert property (@(posedge clk) disable iff (rst)
        (mix_mode && ne_err && fe_err && !rd_en && cnt[CNT_ONE] < CNT_MAX - 1)
        |=> cnt[CNT_ONE] == $past(cnt[CNT_ONE]) + 2); // R2
    AST_READ_OTHER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == CNT_ONE && !fe_err) |=> $stable(cnt[CNT_TWO])); // R6

endmodule

// File: tb/blk_err_thresh_test.sv
module blk_err_thresh_test;
    import errcnt_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ne_err = 1'b0, fe_err = 1'b0, mix_mode = 1'b0;
    logic        rd_en = 1'b0, rd_sel = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [1:0]  evt_req;
    logic [15:0] evt_cnt;

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    blk_err_thresh uut (
        .clk(clk), .rst(rst), .ne_err(ne_err), .fe_err(fe_err), .mix_mode(mix_mode),
        .rd_en(rd_en), .rd_sel(rd_sel), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_data(rd_data), .evt_req(evt_req), .evt_cnt(evt_cnt)
    );

    // [18] ne, [17] fe, [16] mix, [15:8] expected counter one, [7:0] expected counter two
    localparam logic [18:0] VEC [8] = '{
        {1'b1, 1'b0, 1'b1, 8'd1, 8'd0},
        {1'b0, 1'b1, 1'b1, 8'd2, 8'd1},
        {1'b1, 1'b1, 1'b1, 8'd4, 8'd2},
        {1'b1, 1'b1, 1'b0, 8'd5, 8'd3},
        {1'b0, 1'b1, 1'b0, 8'd5, 8'd4},
        {1'b0, 1'b0, 1'b1, 8'd5, 8'd4},
        {1'b1, 1'b0, 1'b0, 8'd6, 8'd4},
        {1'b1, 1'b1, 1'b1, 8'd8, 8'd5}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic peek(output logic [7:0] c1, output logic [7:0] c2);
        rd_sel = 1'b0; #1 c1 = rd_data;
        rd_sel = 1'b1; #1 c2 = rd_data;
        rd_sel = 1'b0; #1;
    endtask

    task automatic step(input logic ne, input logic fe, input logic mix,
                        input logic rd, input logic rsel, output logic [7:0] rdv);
        @(negedge clk);
        ne_err = ne; fe_err = fe; mix_mode = mix; rd_sel = rsel; rd_en = rd;
        #1 rdv = rd_data;
        @(posedge clk);
        @(negedge clk);
        ne_err = 1'b0; fe_err = 1'b0; rd_en = 1'b0; rd_sel = 1'b0;
    endtask

    task automatic write_thr(input logic sel, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] c1, c2, rdv;
        int n_evt1, n_evt2;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        peek(c1, c2);
        check("R1 counter one after reset", {8'd0, c1}, 16'd0);
        check("R1 counter two after reset", {8'd0, c2}, 16'd0);
        check("R1 no event after reset", {14'd0, evt_req}, 16'd0);

        for (int i = 0; i < 8; i++) begin
            step(VEC[i][18], VEC[i][17], VEC[i][16], 1'b0, 1'b0, rdv);
            peek(c1, c2);
            check("R2 R3 counter one table", {8'd0, c1}, {8'd0, VEC[i][15:8]});
            check("R4 counter two table", {8'd0, c2}, {8'd0, VEC[i][7:0]});
            check("R10 no event below default threshold", {14'd0, evt_req}, 16'd0);
        end

        // R6: read counter one, counter two kept
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, rdv);
        check("R6 read value", {8'd0, rdv}, 16'd8);
        peek(c1, c2);
        check("R6 counter one cleared", {8'd0, c1}, 16'd0);
        check("R6 counter two kept", {8'd0, c2}, 16'd5);

        // R7: read counter two with a far-end pulse in the same cycle
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, rdv);
        check("R7 read returns old", {8'd0, rdv}, 16'd5);
        peek(c1, c2);
        check("R7 counter two restarts at 1", {8'd0, c2}, 16'd1);
        check("R2 counter one counted far-end", {8'd0, c1}, 16'd1);

        // R8/R9/R10: threshold 3 on counter one
        write_thr(1'b0, 8'd3);
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, rdv);
        check("R9 no event at 2", {14'd0, evt_req}, 16'd0);
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, rdv);
        check("R8 R9 event on reaching 3", {14'd0, evt_req}, 16'd1);
        check("R9 event count one", {8'd0, evt_cnt[7:0]}, 16'd3);
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, rdv);
        check("R10 no repeat at 4", {14'd0, evt_req}, 16'd0);
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, rdv);
        check("R6 read 4", {8'd0, rdv}, 16'd4);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, rdv);
        check("R9 no event at 2 after clear", {14'd0, evt_req}, 16'd0);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, rdv);
        check("R10 R9 step past threshold fires", {14'd0, evt_req}, 16'd1);
        check("R9 event count 4", {8'd0, evt_cnt[7:0]}, 16'd4);

        // R8: threshold 5 on counter two
        write_thr(1'b1, 8'd5);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, rdv);
        check("R8 counter two at 4 silent", {14'd0, evt_req}, 16'd0);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, rdv);
        check("R8 R9 counter two event", {14'd0, evt_req}, 16'd2);
        check("R9 event count two", {8'd0, evt_cnt[15:8]}, 16'd5);
        peek(c1, c2);
        check("R3 counter one ignores far-end", {8'd0, c1}, 16'd4);

        // R11: zero threshold never fires
        write_thr(1'b0, 8'd0);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, rdv);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, rdv);
        check("R11 zero threshold silent", {14'd0, evt_req}, 16'd0);
        peek(c1, c2);
        check("R11 counter one counted", {8'd0, c1}, 16'd1);

        // R5/R10: saturation with threshold 0xFF
        write_thr(1'b0, 8'hFF);
        n_evt1 = 0;
        n_evt2 = 0;
        for (int i = 0; i < 130; i++) begin
            step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, rdv);
            if (evt_req[0]) n_evt1++;
            if (evt_req[1]) n_evt2++;
        end
        check("R10 one event to saturation", 16'(n_evt1), 16'd1);
        check("R10 counter two above threshold silent", 16'(n_evt2), 16'd0);
        peek(c1, c2);
        check("R5 counter one saturated", {8'd0, c1}, 16'hFF);
        check("R4 counter two value", {8'd0, c2}, 16'd135);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, rdv);
        peek(c1, c2);
        check("R5 stays at 0xFF", {8'd0, c1}, 16'hFF);
        check("R10 no event while saturated", {14'd0, evt_req}, 16'd0);

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        peek(c1, c2);
        check("R1 counter one reset", {8'd0, c1}, 16'd0);
        check("R1 counter two reset", {8'd0, c2}, 16'd0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, rdv);
        check("R1 threshold back to 0xFF", {14'd0, evt_req}, 16'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule